// File: doc/BRIEF.md
# IDE Channel Register Window

This block is the host-side register front end of a two-drive IDE channel on a big-endian bus. Each bus request carries an address, a size code and, for writes, data. Address bits 11:4 select a register index, which gives a 16-byte register stride inside a 4 KB window. Byte requests reach the task-file and control/status registers of the device core. Halfword and word requests reach the data port, and the block reverses the byte order of the data in both directions. The device core itself is outside this block. The block reaches it through per-register read and write strobes, and it takes the core's read data back on combinational inputs.

The block also holds two registers of its own. The first is a 32-bit timing register. The second is an interrupt image register. The image records the DMA interrupt as a latched bit that software clears by writing a one to it, and it records the disk interrupt as a plain copy of the line level. Both interrupt lines also pass straight through to the block's outputs. Every accepted request gets a response one cycle later. For a read, that response carries the read data. Any access that maps to no register reads back all ones for its width.

Top module: `ide_regwin`

## Requirements
- R1: `req_ready_o` is always high. Every request with `req_valid_i` high produces `rsp_valid_o` high in the next cycle. For a read, `rsp_rdata_o` carries the read data in that cycle. For a write, it is zero. No core strobe is asserted while `req_valid_i` is low.
- R2: The register index is `req_addr_i[11:4]`. Address bits 3:0 do not affect decoding. The size code is 0 for byte, 1 for halfword, 2 for word and 3 for reserved.
- R3: A byte request to index 1 to 7 asserts `tf_we_o` or `tf_re_o`, with `tf_idx_o` equal to the index. A write sends `req_wdata_i[7:0]` on `tf_wdata_o`. A read returns `tf_rdata_i` in `rsp_rdata_o[7:0]`, with the upper bits zero.
- R4: A byte write to index 8 or 22 asserts `ctl_we_o`, with `req_wdata_i[7:0]` on `ctl_wdata_o`. A byte read from either index returns `alt_stat_i` in bits 7:0.
- R5: A byte request to any other index asserts no strobe. A byte read of such an index returns 0x000000FF.
- R6: A halfword or word request to index 0 asserts `dp_we_o` or `dp_re_o`. `dp_wide_o` is high for a word request. A halfword write sends `{wdata[7:0],wdata[15:8]}` in `dp_wdata_o[15:0]`, and a word write sends its four bytes in reversed order. Read data from `dp_rdata_i` is reversed in the same way.
- R7: An unmapped halfword read returns 0x0000FFFF. An unmapped word read, or any read with size code 3, returns 0xFFFFFFFF. Such requests assert no strobe.
- R8: A word request to index 0x20 writes or reads the timing register, which resets to zero. A halfword request to index 0x20 leaves the register unchanged.
- R9: A word read of index 0x30 returns the interrupt image, which resets to zero. Bit 31 sets on a rising edge of `dma_irq_i` and clears on a falling edge. Bit 30 follows `disk_irq_i` one cycle later. All other bits read zero.
- R10: A word write to index 0x30 with bit 31 set clears image bit 31. Other written bits, writes with bit 31 clear, and halfword writes all leave the image unchanged.
- R11: `disk_irq_o` equals `disk_irq_i`, and `dma_irq_o` equals `dma_irq_i`, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr_i | input | 12 | Byte address inside the window |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data, right-aligned |
| tf_we_o | output | 1 | Task-file write strobe |
| tf_re_o | output | 1 | Task-file read strobe |
| tf_idx_o | output | 3 | Task-file register index |
| tf_wdata_o | output | 8 | Task-file write data |
| tf_rdata_i | input | 8 | Task-file read data from the core |
| ctl_we_o | output | 1 | Device control write strobe |
| ctl_wdata_o | output | 8 | Device control write data |
| alt_stat_i | input | 8 | Alternate status from the core |
| dp_we_o | output | 1 | Data port write strobe |
| dp_re_o | output | 1 | Data port read strobe |
| dp_wide_o | output | 1 | Data port access is 32-bit |
| dp_wdata_o | output | 32 | Data port write data, byte-reversed |
| dp_rdata_i | input | 32 | Data port read data from the core |
| disk_irq_i | input | 1 | Disk interrupt level |
| dma_irq_i | input | 1 | DMA interrupt level |
| disk_irq_o | output | 1 | Disk interrupt pass-through |
| dma_irq_o | output | 1 | DMA interrupt pass-through |

## Verification
The bench focuses on the places where a wrong decoder would route a request to the wrong target.

- **Second control alias (index 22).** Writes to it must still reach the control register.
- **Nonzero low address bits.** These must not shift the register index.
- **Halfword request to the timing index.** This must fall through as unmapped instead of writing the register.
- **Reserved size code.** This must not be treated as a word access to the data port.

For the data port, the bench uses asymmetric byte patterns, so a missing swap, or a 32-bit swap applied to a halfword, shows up in the value. For the interrupt image, the bench confirms these points:

- The clear-by-writing-one on bit 31 holds while the DMA line stays high.
- The bit sets again only on a new rising edge.
- Writing zero to bit 31, or using a halfword write, leaves the bit set.
- The clear never touches the disk bit.

// File: rtl/ide_regwin_pkg.sv
`timescale 1ns/1ps
package ide_regwin_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} size_e;
  typedef enum logic [2:0] {K_NONE, K_TF, K_CTL, K_DATA, K_TIMING, K_IRQ} kind_e;
  localparam int IDX_TF_LO  = 1;
  localparam int IDX_TF_HI  = 7;
  localparam int IDX_CTL_A  = 8;
  localparam int IDX_CTL_B  = 22;
  localparam int IDX_TIMING = 32;
  localparam int IDX_IRQ    = 48;
  localparam int DMA_BIT    = 31;
  localparam int DISK_BIT   = 30;
endpackage

// File: rtl/ide_regwin_dec.sv
`timescale 1ns/1ps
module ide_regwin_dec
  import ide_regwin_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       size_i,
  output kind_e            kind_o
);
  always_comb begin
    kind_o = K_NONE;
    case (size_e'(size_i))
      SZ_BYTE: begin
        if (idx_i >= IDX_W'(IDX_TF_LO) && idx_i <= IDX_W'(IDX_TF_HI)) kind_o = K_TF;
        else if (idx_i == IDX_W'(IDX_CTL_A) || idx_i == IDX_W'(IDX_CTL_B)) kind_o = K_CTL;
      end
      SZ_HALF: begin
        if (idx_i == '0) kind_o = K_DATA;
      end
      SZ_WORD: begin
        if (idx_i == '0) kind_o = K_DATA;
        else if (idx_i == IDX_W'(IDX_TIMING)) kind_o = K_TIMING;
        else if (idx_i == IDX_W'(IDX_IRQ)) kind_o = K_IRQ;
      end
      default: kind_o = K_NONE;
    endcase
  end
endmodule

// File: rtl/ide_regwin_swap.sv
`timescale 1ns/1ps
module ide_regwin_swap #(
  parameter int BYTES = 4
) (
  input  logic [8*BYTES-1:0] d_i,
  output logic [8*BYTES-1:0] d_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign d_o[8*b +: 8] = d_i[8*(BYTES-1-b) +: 8];
  end
endmodule

// File: rtl/ide_regwin_irq.sv
`timescale 1ns/1ps
module ide_regwin_irq
  import ide_regwin_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dma_lvl_i,
  input  logic          disk_lvl_i,
  input  logic          clr_dma_i,
  output logic [DW-1:0] img_o
);
  logic dma_prev_q, dma_q, disk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_prev_q <= 1'b0;
      dma_q      <= 1'b0;
      disk_q     <= 1'b0;
    end else begin
      dma_prev_q <= dma_lvl_i;
      disk_q     <= disk_lvl_i;
      // A level change wins over a software clear in the same cycle
      if (dma_lvl_i && !dma_prev_q)      dma_q <= 1'b1;
      else if (!dma_lvl_i && dma_prev_q) dma_q <= 1'b0;
      else if (clr_dma_i)                dma_q <= 1'b0;
    end
  end

  always_comb begin
    img_o           = '0;
    img_o[DMA_BIT]  = dma_q;
    img_o[DISK_BIT] = disk_q;
  end
endmodule

// File: rtl/ide_regwin.sv
`timescale 1ns/1ps
module ide_regwin
  import ide_regwin_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic              tf_we_o,
  output logic              tf_re_o,
  output logic [2:0]        tf_idx_o,
  output logic [7:0]        tf_wdata_o,
  input  logic [7:0]        tf_rdata_i,
  output logic              ctl_we_o,
  output logic [7:0]        ctl_wdata_o,
  input  logic [7:0]        alt_stat_i,
  output logic              dp_we_o,
  output logic              dp_re_o,
  output logic              dp_wide_o,
  output logic [DW-1:0]     dp_wdata_o,
  input  logic [DW-1:0]     dp_rdata_i,
  input  logic              disk_irq_i,
  input  logic              dma_irq_i,
  output logic              disk_irq_o,
  output logic              dma_irq_o
);
  localparam int STRIDE_B = 4;
  localparam int IDX_W    = ADDR_W - STRIDE_B;
  localparam int HW       = DW / 2;

  logic [IDX_W-1:0] idx;
  kind_e            kind;
  logic             wr_acc, rd_acc, wide;
  logic [HW-1:0]    wr16, rd16;
  logic [DW-1:0]    wr32, rd32;
  logic [DW-1:0]    timing_q, irq_img, rd_data;
  logic             clr_dma;
  logic             rsp_valid_q;
  logic [DW-1:0]    rsp_rdata_q;
  logic             unused_bits;

  assign idx         = req_addr_i[ADDR_W-1:STRIDE_B];
  assign unused_bits = ^req_addr_i[STRIDE_B-1:0];
  assign wr_acc      = req_valid_i && req_write_i;
  assign rd_acc      = req_valid_i && !req_write_i;
  assign wide        = (size_e'(req_size_i) == SZ_WORD);

  ide_regwin_dec #(.IDX_W(IDX_W)) dec_i (.idx_i(idx), .size_i(req_size_i), .kind_o(kind));

  ide_regwin_swap #(.BYTES(2))    sw_w16_i (.d_i(req_wdata_i[HW-1:0]), .d_o(wr16));
  ide_regwin_swap #(.BYTES(DW/8)) sw_w32_i (.d_i(req_wdata_i),         .d_o(wr32));
  ide_regwin_swap #(.BYTES(2))    sw_r16_i (.d_i(dp_rdata_i[HW-1:0]),  .d_o(rd16));
  ide_regwin_swap #(.BYTES(DW/8)) sw_r32_i (.d_i(dp_rdata_i),          .d_o(rd32));

  assign clr_dma = wr_acc && kind == K_IRQ && req_wdata_i[DMA_BIT];

  ide_regwin_irq #(.DW(DW)) irq_i (
    .clk_i, .rst_ni,
    .dma_lvl_i (dma_irq_i),
    .disk_lvl_i(disk_irq_i),
    .clr_dma_i (clr_dma),
    .img_o     (irq_img)
  );

  // Core strobes
  assign tf_we_o     = wr_acc && kind == K_TF;
  assign tf_re_o     = rd_acc && kind == K_TF;
  assign tf_idx_o    = idx[2:0];
  assign tf_wdata_o  = req_wdata_i[7:0];
  assign ctl_we_o    = wr_acc && kind == K_CTL;
  assign ctl_wdata_o = req_wdata_i[7:0];
  assign dp_we_o     = wr_acc && kind == K_DATA;
  assign dp_re_o     = rd_acc && kind == K_DATA;
  assign dp_wide_o   = wide;
  assign dp_wdata_o  = wide ? wr32 : {{(DW-HW){1'b0}}, wr16};

  assign disk_irq_o  = disk_irq_i;
  assign dma_irq_o   = dma_irq_i;
  assign req_ready_o = 1'b1;

  always_comb begin
    case (kind)
      K_TF:     rd_data = {{(DW-8){1'b0}}, tf_rdata_i};
      K_CTL:    rd_data = {{(DW-8){1'b0}}, alt_stat_i};
      K_DATA:   rd_data = wide ? rd32 : {{(DW-HW){1'b0}}, rd16};
      K_TIMING: rd_data = timing_q;
      K_IRQ:    rd_data = irq_img;
      default: begin
        case (size_e'(req_size_i))
          SZ_BYTE: rd_data = {{(DW-8){1'b0}}, 8'hFF};
          SZ_HALF: rd_data = {{(DW-HW){1'b0}}, {HW{1'b1}}};
          default: rd_data = '1;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timing_q    <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      if (wr_acc && kind == K_TIMING) timing_q <= req_wdata_i;
      rsp_valid_q <= req_valid_i;
      rsp_rdata_q <= rd_acc ? rd_data : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
endmodule

// File: rtl/ide_regwin_chk.sv
`timescale 1ns/1ps
module ide_regwin_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          rsp_valid_o,
  input logic [DW-1:0] req_wdata_i,
  input logic          tf_we_o,
  input logic          tf_re_o,
  input logic [2:0]    tf_idx_o,
  input logic          ctl_we_o,
  input logic          dp_we_o,
  input logic          dp_re_o,
  input logic          dp_wide_o,
  input logic [DW-1:0] dp_wdata_o,
  input logic          dma_irq_i,
  input logic [DW-1:0] irq_img
);
  assert_rsp_next_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(tf_we_o || tf_re_o || ctl_we_o || dp_we_o || dp_re_o));

  assert_one_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tf_we_o, tf_re_o, ctl_we_o, dp_we_o, dp_re_o}));

  assert_tf_idx_mapped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tf_we_o || tf_re_o) |-> tf_idx_o != 3'd0);

  assert_half_swap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_we_o && !dp_wide_o) |->
      dp_wdata_o == {{(DW-16){1'b0}}, req_wdata_i[7:0], req_wdata_i[15:8]});

  assert_dma_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_irq_i) |=> irq_img[31]);

  assert_dma_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dma_irq_i) |=> !irq_img[31]);
endmodule

bind ide_regwin ide_regwin_chk #(.DW(DW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .rsp_valid_o(rsp_valid_o),
  .req_wdata_i(req_wdata_i),
  .tf_we_o    (tf_we_o),
  .tf_re_o    (tf_re_o),
  .tf_idx_o   (tf_idx_o),
  .ctl_we_o   (ctl_we_o),
  .dp_we_o    (dp_we_o),
  .dp_re_o    (dp_re_o),
  .dp_wide_o  (dp_wide_o),
  .dp_wdata_o (dp_wdata_o),
  .dma_irq_i  (dma_irq_i),
  .irq_img    (irq_img)
);

// File: tb/ide_regwin_tb_top.sv
`timescale 1ns/1ps
module ide_regwin_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [1:0]  req_size_i = 2'd0;
  logic [11:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic        tf_we_o, tf_re_o, ctl_we_o, dp_we_o, dp_re_o, dp_wide_o;
  logic [2:0]  tf_idx_o;
  logic [7:0]  tf_wdata_o, ctl_wdata_o;
  logic [31:0] dp_wdata_o;
  logic [7:0]  tf_rdata_i = 8'hA5, alt_stat_i = 8'h50;
  logic [31:0] dp_rdata_i = 32'h11223344;
  logic        disk_irq_i = 1'b0, dma_irq_i = 1'b0, disk_irq_o, dma_irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // Captured during the request cycle and the response cycle
  logic [4:0]  s_stb;
  logic [2:0]  s_idx;
  logic [7:0]  s_tfw, s_ctlw;
  logic [31:0] s_dpw;
  logic        s_wide, s_ready, r_valid;
  logic [31:0] r_data;

  always #5 clk_i = ~clk_i;

  ide_regwin dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [1:0] sz, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_size_i = sz; req_addr_i = a; req_wdata_i = d;
    #1;
    s_stb   = {tf_we_o, tf_re_o, ctl_we_o, dp_we_o, dp_re_o};
    s_idx   = tf_idx_o; s_tfw = tf_wdata_o; s_ctlw = ctl_wdata_o;
    s_dpw   = dp_wdata_o; s_wide = dp_wide_o; s_ready = req_ready_o;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    r_valid = rsp_valid_o; r_data = rsp_rdata_o;
  endtask

  task automatic t_reset;
    check("R1 reset rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
    access(0, 2'd2, 12'h200, 0);
    check("R8 timing reset", r_data, 32'h0);
    access(0, 2'd2, 12'h300, 0);
    check("R9 irq image reset", r_data, 32'h0);
    check("R1 rsp_valid after read", {31'd0, r_valid}, 32'd1);
  endtask

  task automatic t_taskfile;
    access(1, 2'd0, 12'h034, 32'hFFFF_FFC7);
    check("R3 tf write strobes", {27'd0, s_stb}, 32'b10000);
    check("R3 tf write idx", {29'd0, s_idx}, 32'd3);
    check("R3 tf write data", {24'd0, s_tfw}, 32'hC7);
    check("R1 ready", {31'd0, s_ready}, 32'd1);
    check("R1 write rsp data zero", r_data, 32'h0);
    access(0, 2'd0, 12'h01F, 0);
    check("R2 low bits ignored strobes", {27'd0, s_stb}, 32'b01000);
    check("R2 low bits ignored idx", {29'd0, s_idx}, 32'd1);
    check("R3 tf read data", r_data, 32'h0000_00A5);
    access(0, 2'd0, 12'h07C, 0);
    check("R3 tf idx 7", {29'd0, s_idx}, 32'd7);
  endtask

  task automatic t_control;
    access(1, 2'd0, 12'h080, 32'h0000_0006);
    check("R4 ctl idx8 strobe", {27'd0, s_stb}, 32'b00100);
    check("R4 ctl idx8 data", {24'd0, s_ctlw}, 32'h06);
    access(1, 2'd0, 12'h160, 32'h0000_0002);
    check("R4 ctl idx22 strobe", {27'd0, s_stb}, 32'b00100);
    check("R4 ctl idx22 data", {24'd0, s_ctlw}, 32'h02);
    access(0, 2'd0, 12'h160, 0);
    check("R4 alt status idx22", r_data, 32'h50);
    access(0, 2'd0, 12'h080, 0);
    check("R4 alt status idx8", r_data, 32'h50);
  endtask

  task automatic t_byte_unmapped;
    access(0, 2'd0, 12'h000, 0);
    check("R5 byte idx0 read", r_data, 32'h0000_00FF);
    check("R5 byte idx0 no strobe", {27'd0, s_stb}, 32'd0);
    access(1, 2'd0, 12'h090, 32'h55);
    check("R5 byte idx9 write no strobe", {27'd0, s_stb}, 32'd0);
  endtask

  task automatic t_dataport;
    access(1, 2'd1, 12'h000, 32'h0000_BEEF);
    check("R6 half write strobe", {27'd0, s_stb}, 32'b00010);
    check("R6 half not wide", {31'd0, s_wide}, 32'd0);
    check("R6 half write swap", s_dpw, 32'h0000_EFBE);
    access(1, 2'd2, 12'h000, 32'h1234_5678);
    check("R6 word wide", {31'd0, s_wide}, 32'd1);
    check("R6 word write swap", s_dpw, 32'h7856_3412);
    access(0, 2'd1, 12'h000, 0);
    check("R6 half read strobe", {27'd0, s_stb}, 32'b00001);
    check("R6 half read swap", r_data, 32'h0000_4433);
    access(0, 2'd2, 12'h000, 0);
    check("R6 word read swap", r_data, 32'h4433_2211);
  endtask

  task automatic t_unmapped_wide;
    access(0, 2'd1, 12'h200, 0);
    check("R7 half unmapped", r_data, 32'h0000_FFFF);
    check("R7 half unmapped no strobe", {27'd0, s_stb}, 32'd0);
    access(0, 2'd2, 12'h100, 0);
    check("R7 word unmapped", r_data, 32'hFFFF_FFFF);
    access(0, 2'd3, 12'h000, 0);
    check("R7 reserved size read", r_data, 32'hFFFF_FFFF);
    check("R7 reserved size no strobe", {27'd0, s_stb}, 32'd0);
  endtask

  task automatic t_timing;
    access(1, 2'd2, 12'h200, 32'hCAFE_F00D);
    access(0, 2'd2, 12'h204, 0);
    check("R8 timing readback", r_data, 32'hCAFE_F00D);
    access(1, 2'd1, 12'h200, 32'h0000_1234);
    access(0, 2'd2, 12'h200, 0);
    check("R8 half write ignored", r_data, 32'hCAFE_F00D);
  endtask

  task automatic t_irq;
    @(negedge clk_i); dma_irq_i = 1'b1; #1;
    check("R11 dma pass-through", {31'd0, dma_irq_o}, 32'd1);
    access(0, 2'd2, 12'h300, 0);
    check("R9 dma bit set", r_data, 32'h8000_0000);
    @(negedge clk_i); disk_irq_i = 1'b1; #1;
    check("R11 disk pass-through", {31'd0, disk_irq_o}, 32'd1);
    access(0, 2'd2, 12'h300, 0);
    check("R9 disk bit set", r_data, 32'hC000_0000);
    access(1, 2'd2, 12'h300, 32'h7FFF_FFFF);
    access(0, 2'd2, 12'h300, 0);
    check("R10 bit31 clear write no effect", r_data, 32'hC000_0000);
    access(1, 2'd1, 12'h300, 32'hFFFF_FFFF);
    access(0, 2'd2, 12'h300, 0);
    check("R10 half write no effect", r_data, 32'hC000_0000);
    access(1, 2'd2, 12'h300, 32'hFFFF_FFFF);
    access(0, 2'd2, 12'h300, 0);
    check("R10 w1c clears only dma", r_data, 32'h4000_0000);
    check("R11 dma still high after w1c", {31'd0, dma_irq_o}, 32'd1);
    @(negedge clk_i); disk_irq_i = 1'b0;
    access(0, 2'd2, 12'h300, 0);
    check("R9 disk bit follows low", r_data, 32'h0);
    @(negedge clk_i); dma_irq_i = 1'b0;
    @(negedge clk_i); dma_irq_i = 1'b1;
    access(0, 2'd2, 12'h300, 0);
    check("R9 dma re-sets on new edge", r_data, 32'h8000_0000);
    @(negedge clk_i); dma_irq_i = 1'b0;
    access(0, 2'd2, 12'h300, 0);
    check("R9 dma falling edge clears", r_data, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_taskfile();
    t_control();
    t_byte_unmapped();
    t_dataport();
    t_unmapped_wide();
    t_timing();
    t_irq();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule